// File: doc/BRIEF.md
# Synchronous Rectifier Gate Timing Logic

This block turns the two primary-side PWM waveforms of a resonant converter into two gate requests for the secondary synchronous rectifier switches. Each channel watches one primary PWM. A rising edge on that PWM turns the channel's gate request on. The request turns off again at the next falling edge of the same PWM, or after a programmable maximum on-time, whichever comes first.

When the switching period is shorter than the resonant period, the falling edge ends the pulse (resonant operation). When it is longer, the on-time limit cuts the pulse off at about half the resonant period (clamped operation). The outputs are action-level requests: a dead-band stage placed after this block adds the turn-on delay. A global enable turns rectification on or off as a whole.

Each channel keeps a set/reset state bit. A turn-on strobe sets it when it is low. The OR of the falling-edge strobe and an on-time counter match clears it when it is high. The counter runs only while the state bit is high.

Top module: `sr_gate_timer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both `gateA` and `gateB` are low.
- R2: When enabled and the gate is low, a low-to-high change of `pwmA` that is set up before clock edge N makes `gateA` high from clock edge N+1.
- R3: With `maxOnTime` at zero, or larger than the primary high time, `gateA` stays high for exactly as many cycles as `pwmA` was high. It falls one edge after the register that captures the low level of `pwmA`.
- R4: With a non-zero `maxOnTime` smaller than the primary high time, `gateA` stays high for exactly `maxOnTime` cycles. It then stays low until the next rising edge of `pwmA`.
- R5: `gateB` follows `pwmB` with the same timing, and the same on-time limit, as `gateA` follows `pwmA`. Each channel has its own counter, and activity on one PWM leaves the other gate low.
- R6: While `srEnable` is low, both gates are forced low from the clock edge that samples it low, even in the middle of a pulse.
- R7: Raising `srEnable` while a primary PWM is already high does not turn its gate on. Only a later rising edge of that PWM does.
- R8: `maxOnTime` equal to zero disables the on-time clamp, so only the falling edge of the PWM ends the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srEnable | input | 1 | Global rectification enable; low forces both gates off |
| pwmA | input | 1 | Primary PWM feeding channel A |
| pwmB | input | 1 | Primary PWM feeding channel B |
| maxOnTime | input | CNT_W | Maximum on-time in clock cycles; 0 disables the clamp |
| gateA | output | 1 | Gate request for rectifier switch A |
| gateB | output | 1 | Gate request for rectifier switch B |

## Verification
The on-time assertions assume that `maxOnTime` changes only while both gates are low. They also assume that each primary PWM holds its level for at least one clock, so that the edge strobes of one channel never overlap. The stimulus meets both assumptions. It drives every input at the falling clock edge, changes the limit only between pulses, and leaves at least three low cycles after each pulse so that the gate has settled before the next rising edge.

// File: rtl/sr_gate_pkg.sv
package sr_gate_pkg;
  // Channel 0 serves gate A, channel 1 serves gate B
  localparam int NUM_CH = 2;

  // Strobes from edge control to the state/counter datapath
  typedef struct packed {
    logic [NUM_CH-1:0] turnOn;   // primary rising-edge pulse per channel
    logic [NUM_CH-1:0] turnOff;  // primary falling-edge pulse per channel
  } edge_strobe_t;
endpackage

// File: rtl/sr_edge_ctrl.sv
module sr_edge_ctrl
  import sr_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] pwmIn,
  output edge_strobe_t      strobes
);
  logic [NUM_CH-1:0] pwmNow;
  logic [NUM_CH-1:0] pwmPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwmNow  <= '0;
      pwmPrev <= '0;
    end else begin
      pwmNow  <= pwmIn;
      pwmPrev <= pwmNow;
    end
  end

  // Each strobe is high for one cycle, one clock after the level is captured
  always_comb begin
    strobes.turnOn  = pwmNow & ~pwmPrev;
    strobes.turnOff = ~pwmNow & pwmPrev;
  end
endmodule

// File: rtl/sr_gate_datapath.sv
module sr_gate_datapath
  import sr_gate_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [CNT_W-1:0]  maxOn,
  input  edge_strobe_t      strobes,
  output logic [NUM_CH-1:0] gate
);
  localparam int EXT_W = CNT_W + 1;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic             stateQ;
    logic             stateNext;
    logic [CNT_W-1:0] onCnt;
    logic             limitHit;
    logic             offEvt;

    // Match fires on the last allowed cycle; a zero limit never matches
    assign limitHit = stateQ &&
                      ((EXT_W'(onCnt) + EXT_W'(1)) == EXT_W'(maxOn));
    assign offEvt   = strobes.turnOff[ch] | limitHit;

    // Set while low on turn-on; clear while high on the OR'd turn-off
    assign stateNext = (~stateQ & strobes.turnOn[ch]) | (stateQ & ~offEvt);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stateQ <= 1'b0;
      end else begin
        stateQ <= enable ? stateNext : 1'b0;
      end
    end

    // On-time counter: cleared while the state bit is low, saturates at limit
    always_ff @(posedge clk) begin
      if (!rstN || !stateQ) begin
        onCnt <= '0;
      end else if (onCnt != maxOn) begin
        onCnt <= onCnt + CNT_W'(1);
      end
    end

    assign gate[ch] = stateQ;
  end
endmodule

// File: rtl/sr_gate_timer.sv
module sr_gate_timer
  import sr_gate_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             srEnable,
  input  logic             pwmA,
  input  logic             pwmB,
  input  logic [CNT_W-1:0] maxOnTime,
  output logic             gateA,
  output logic             gateB
);
  edge_strobe_t      edgeStrobes;
  logic [NUM_CH-1:0] gateVec;

  sr_edge_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .pwmIn   ({pwmB, pwmA}),
    .strobes (edgeStrobes)
  );

  sr_gate_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (srEnable),
    .maxOn   (maxOnTime),
    .strobes (edgeStrobes),
    .gate    (gateVec)
  );

  assign gateA = gateVec[0];
  assign gateB = gateVec[1];
endmodule

// File: rtl/sr_gate_timer_chk.sv
module sr_gate_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             srEnable,
  input logic [CNT_W-1:0] maxOnTime,
  input logic             gateA,
  input logic             gateB,
  input logic [1:0]       turnOn,
  input logic [1:0]       turnOff
);
  localparam int RUN_W = CNT_W + 1;

  logic [RUN_W-1:0] runA;
  logic [RUN_W-1:0] runB;

  // Length of the current high run of each gate, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runA <= '0;
      runB <= '0;
    end else begin
      runA <= !gateA ? '0 : ((&runA) ? runA : runA + RUN_W'(1));
      runB <= !gateB ? '0 : ((&runB) ? runB : runB + RUN_W'(1));
    end
  end

  // R6
  gates_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !srEnable |=> (!gateA && !gateB));

  // R2
  gate_a_rise_needs_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateA) |-> $past(turnOn[0]));

  // R5
  gate_b_rise_needs_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateB) |-> $past(turnOn[1]));

  // R2
  gate_a_turn_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (turnOn[0] && !gateA && srEnable) |=> gateA);

  // R3
  gate_a_turn_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (turnOff[0] && gateA) |=> !gateA);

  // R5
  gate_b_turn_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (turnOff[1] && gateB) |=> !gateB);

  // R4
  gate_a_max_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maxOnTime != '0 && runA == RUN_W'(maxOnTime)) |-> !gateA);

  // R5
  gate_b_max_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maxOnTime != '0 && runB == RUN_W'(maxOnTime)) |-> !gateB);
endmodule

bind sr_gate_timer sr_gate_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .srEnable  (srEnable),
  .maxOnTime (maxOnTime),
  .gateA     (gateA),
  .gateB     (gateB),
  .turnOn    (edgeStrobes.turnOn),
  .turnOff   (edgeStrobes.turnOff)
);

// File: tb/tb_sr_gate_timer.sv
module tb_sr_gate_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;

  logic             clk = 1'b0;
  logic             rstN;
  logic             srEnable;
  logic             pwmA;
  logic             pwmB;
  logic [CNT_W-1:0] maxOnTime;
  logic             gateA;
  logic             gateB;

  int  checkCnt = 0;
  int  failCnt  = 0;
  bit  done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sr_gate_timer #(.CNT_W(CNT_W)) dut (
    .clk       (clk),
    .rstN      (rstN),
    .srEnable  (srEnable),
    .pwmA      (pwmA),
    .pwmB      (pwmB),
    .maxOnTime (maxOnTime),
    .gateA     (gateA),
    .gateB     (gateB)
  );

  task automatic check(input string req, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one pulse on channel ch (0=A, 1=B) of hi cycles, then lo low cycles.
  task automatic runPulse(input int ch, input int hi, input int lo,
                          input int expWidth, input string req);
    int first = -1;
    int width = 0;
    int other = 0;
    if (ch == 0) pwmA = 1'b1; else pwmB = 1'b1;
    for (int c = 1; c <= hi + lo; c++) begin
      @(negedge clk);
      if ((ch == 0 ? gateA : gateB) == 1'b1) begin
        if (first < 0) first = c;
        width++;
      end
      if ((ch == 0 ? gateB : gateA) == 1'b1) other++;
      if (c == hi) begin
        if (ch == 0) pwmA = 1'b0; else pwmB = 1'b0;
      end
    end
    check({req, " width"}, width, expWidth);
    if (expWidth > 0) check({req, " turn-on delay (R2)"}, first, 2);
    check("R5 other channel idle", other, 0);
  endtask

  initial begin
    rstN      = 1'b0;
    srEnable  = 1'b1;
    pwmA      = 1'b1;
    pwmB      = 1'b1;
    maxOnTime = '0;
    repeat (3) @(negedge clk);
    check("R1 gateA in reset", int'(gateA), 0);
    check("R1 gateB in reset", int'(gateB), 0);
    pwmA = 1'b0;
    pwmB = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R1 gateA after reset", int'(gateA), 0);
    check("R1 gateB after reset", int'(gateB), 0);
    repeat (3) @(negedge clk);

    // Sweep limit and high time on both channels: width = min(hi, limit) or hi
    for (int ch = 0; ch < 2; ch++) begin
      for (int lim = 0; lim <= 6; lim++) begin
        maxOnTime = CNT_W'(lim);
        for (int hi = 1; hi <= 8; hi++) begin
          int expW;
          expW = (lim == 0 || hi <= lim) ? hi : lim;
          if (lim == 0)
            runPulse(ch, hi, 4, expW, ch == 0 ? "R8 no clamp A" : "R8 R5 no clamp B");
          else if (hi <= lim)
            runPulse(ch, hi, 4, expW, ch == 0 ? "R3 resonant A" : "R5 resonant B");
          else
            runPulse(ch, hi, 4, expW, ch == 0 ? "R4 clamped A" : "R5 clamped B");
        end
      end
    end

    // R4: after a clamp the later falling edge leaves the gate low
    maxOnTime = CNT_W'(2);
    runPulse(0, 12, 4, 2, "R4 stays low after clamp");

    // R6: disabled, a full pulse gives no gate
    maxOnTime = '0;
    srEnable  = 1'b0;
    runPulse(0, 5, 4, 0, "R6 disabled A");
    runPulse(1, 5, 4, 0, "R6 disabled B");
    srEnable  = 1'b1;

    // R6: dropping enable mid-pulse cuts the gate one edge later
    begin
      int width = 0;
      pwmA = 1'b1;
      for (int c = 1; c <= 12; c++) begin
        @(negedge clk);
        if (gateA) width++;
        if (c == 4) srEnable = 1'b0;
        if (c == 8) pwmA = 1'b0;
      end
      check("R6 mid-pulse disable width", width, 3);
      srEnable = 1'b1;
    end

    // R7: enable raised while pwmA already high does not start a pulse
    begin
      int width = 0;
      srEnable = 1'b0;
      pwmA = 1'b1;
      repeat (3) @(negedge clk);
      srEnable = 1'b1;
      for (int c = 1; c <= 5; c++) begin
        @(negedge clk);
        if (gateA) width++;
      end
      check("R7 no turn-on without edge", width, 0);
      pwmA = 1'b0;
      repeat (4) @(negedge clk);
      runPulse(0, 3, 4, 3, "R7 next edge turns on");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end
endmodule